// File: doc/BRIEF.md
# Video Line and Frame Timing Generator

This block turns the system clock into the raster timing of a video output. It divides the clock into line periods for one of two video standards: a 60 Hz standard with 263 lines per frame, or a 50 Hz standard with 314 lines per frame. It counts lines within the frame. Vertical blanking starts at line 240, and a vertical-blank interrupt is raised at that point. The frame ends after the standard's line total.

At every frame boundary the block does three things:
- It restarts the line count.
- It advances a frame counter.
- It emits a one-cycle unblank pulse. Neighbouring timers running in reset-on-unblank sync modes use this pulse to restart their count.

An interlace field bit is also produced and reported in a 32-bit status word. When both interlace configuration bits are set, the field follows the parity of the frame counter. The standard select and the interlace configuration are taken only at a frame boundary, so a frame never mixes two settings. All pins are plain control and status signals. No stream interface exists, so there is no back-pressure.

Top module: `vt_timing_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `line_num_o`, `frame_cnt_o`, `field_o`, `blank_o`, `line_tick_o`, `unblank_o` and `vblank_irq_o` are 0, and `status_o` equals 32'h0000_2000.
- R2: The line period is P = SYS_CLK_HZ / rate / line_total. This uses integer division, with the rate and total of the active standard. `line_tick_o` is a one-cycle pulse in the first cycle of every new line, P cycles after the previous one. The first pulse comes P cycles after reset release.
- R3: A frame holds 263 lines when the active standard is 0 (60 Hz) and 314 lines when it is 1 (50 Hz). `line_num_o` counts from 0 to the total minus one.
- R4: `blank_o` is 1 exactly while `line_num_o` is 240 or more, and 0 on lines 0 to 239.
- R5: `vblank_irq_o` is a one-cycle pulse in the first cycle of line 240 and at no other time.
- R6: When the last line ends, three things happen in the same cycle: `line_num_o` returns to 0, `frame_cnt_o` increments (modulo 2^FCNT_W), and `unblank_o` pulses for one cycle. Blanking ends in that cycle.
- R7: `std_sel_i` is sampled only at the frame boundary of R6. Changes in the middle of a frame have no effect on that frame. After reset the 60 Hz standard is active until the first boundary.
- R8: `lace_cfg_i` is sampled at the frame boundary. If the sampled value is 2'b11, `field_o` becomes bit 0 of the new frame count. Otherwise `field_o` becomes 0.
- R9: `status_o` holds the following fields, with all other bits 0:
  - bit 31: `field_o`
  - bit 30: `blank_o`
  - bit 29: the active standard
  - bits 28:27: the sampled interlace configuration
  - bit 13: the inverse of `field_o`

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_sel_i | input | 1 | Standard request, 0 = 60 Hz, 1 = 50 Hz |
| lace_cfg_i | input | 2 | Interlace configuration bits |
| line_tick_o | output | 1 | One-cycle pulse at each new line |
| blank_o | output | 1 | Vertical blanking active |
| unblank_o | output | 1 | One-cycle frame-start pulse for timers |
| vblank_irq_o | output | 1 | One-cycle vertical-blank interrupt |
| field_o | output | 1 | Interlace field |
| line_num_o | output | 9 | Current line within the frame |
| frame_cnt_o | output | FCNT_W | Frame counter |
| status_o | output | 32 | Status word |

## Verification
All results are measured against a cycle count that starts at reset release.
- Line L of a frame beginning at cycle S starts at cycle S + L·P. The registered tick, line number and blank flag all change in that cycle.
- The interrupt is therefore due at S + 240·P, and the frame boundary at S + total·P.
- The new frame count, field and status appear in the same cycle as the unblank pulse.

The bench predicts every interrupt and boundary cycle in advance from the standard it drives into the previous frame. It samples on the falling edge and flags both early events and late ones. It also moves the standard and interlace inputs twice in the middle of each frame, to show that only the value held at the boundary counts.

// File: rtl/vt_pkg.sv
package vt_pkg;

  typedef enum logic {
    STD_A = 1'b0,   // 60 Hz standard
    STD_B = 1'b1    // 50 Hz standard
  } vstd_e;

  // status word field positions
  localparam int ST_FIELD   = 31;
  localparam int ST_BLANK   = 30;
  localparam int ST_STD     = 29;
  localparam int ST_LACE_HI = 28;
  localparam int ST_LACE_LO = 27;
  localparam int ST_HALF    = 13;

  localparam logic [1:0] LACE_ON = 2'b11;

  function automatic int unsigned line_period(input int unsigned clk_hz,
                                              input int unsigned rate,
                                              input int unsigned lines);
    return clk_hz / rate / lines;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vt_line_divider.sv
module vt_line_divider
  import vt_pkg::*;
#(
  parameter int unsigned PER_W = 12,
  parameter int unsigned PER_A = 2146,
  parameter int unsigned PER_B = 2157
) (
  input  logic  clk,
  input  logic  rst_n,
  input  vstd_e std_q,
  output logic  tick_end,
  output logic  line_tick
);

  localparam logic [PER_W-1:0] LAST_A = PER_W'(PER_A - 1);
  localparam logic [PER_W-1:0] LAST_B = PER_W'(PER_B - 1);

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] last_c;

  assign last_c   = (std_q == STD_B) ? LAST_B : LAST_A;
  assign tick_end = (cnt_q == last_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      line_tick <= 1'b0;
    end else begin
      cnt_q     <= tick_end ? '0 : cnt_q + 1'b1;
      line_tick <= tick_end;
    end
  end

  // R2: a tick lasts a single cycle (periods are longer than one cycle)
  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick |=> !line_tick);

  // R2: the divider never runs past the period of the active standard
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_c);

  // R2: a tick follows the cycle the divider reached its last count
  a_r2_tick_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick |-> cnt_q == '0);

endmodule

// File: rtl/vt_frame_seq.sv
module vt_frame_seq
  import vt_pkg::*;
#(
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned LINES_A  = 263,
  parameter int unsigned LINES_B  = 314,
  parameter int unsigned VBL_LINE = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_end,
  input  logic              std_sel_i,
  output vstd_e             std_q,
  output logic [LINE_W-1:0] line_q,
  output logic              blank,
  output logic              unblank,
  output logic              vblank_irq,
  output logic              frame_end
);

  localparam logic [LINE_W-1:0] TOP_A = LINE_W'(LINES_A - 1);
  localparam logic [LINE_W-1:0] TOP_B = LINE_W'(LINES_B - 1);
  localparam logic [LINE_W-1:0] VBL_L = LINE_W'(VBL_LINE);

  logic [LINE_W-1:0] top_c;
  logic [LINE_W-1:0] line_inc;
  logic              at_top;
  logic              enter_vbl;

  assign top_c     = (std_q == STD_B) ? TOP_B : TOP_A;
  assign at_top    = (line_q == top_c);
  assign line_inc  = line_q + 1'b1;
  assign frame_end = tick_end && at_top;
  assign enter_vbl = tick_end && !at_top && (line_inc == VBL_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q     <= '0;
      std_q      <= STD_A;
      blank      <= 1'b0;
      unblank    <= 1'b0;
      vblank_irq <= 1'b0;
    end else begin
      unblank    <= frame_end;
      vblank_irq <= enter_vbl;
      if (tick_end) begin
        line_q <= at_top ? '0 : line_inc;
      end
      if (frame_end) begin
        std_q <= vstd_e'(std_sel_i);
        blank <= 1'b0;
      end else if (enter_vbl) begin
        blank <= 1'b1;
      end
    end
  end

  // R5: the interrupt coincides with the first cycle of the blanking line
  a_r5_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |-> (line_q == VBL_L) && blank);

  // R5: one cycle only
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |=> !vblank_irq);

  // R4: blanking only rises together with the interrupt
  a_r4_blank_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank) |-> vblank_irq);

  // R4: blanking never covers visible lines
  a_r4_blank_range: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> line_q >= VBL_L);

  // R6: frame start lands on line 0 with blanking off
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    unblank |-> (line_q == '0) && !blank);

  // R7: the standard changes only at a frame boundary
  a_r7_std_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !unblank |-> $stable(std_q));

endmodule

// File: rtl/vt_field_status.sv
module vt_field_status
  import vt_pkg::*;
#(
  parameter int unsigned FCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [1:0]        lace_cfg_i,
  input  logic              blank,
  input  vstd_e             std_q,
  output logic [FCNT_W-1:0] frame_cnt,
  output logic              field,
  output logic [31:0]       status
);

  logic [1:0]        lace_q;
  logic [FCNT_W-1:0] cnt_nxt;

  assign cnt_nxt = frame_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_cnt <= '0;
      lace_q    <= '0;
      field     <= 1'b0;
    end else if (frame_end) begin
      frame_cnt <= cnt_nxt;
      lace_q    <= lace_cfg_i;
      field     <= (lace_cfg_i == LACE_ON) ? cnt_nxt[0] : 1'b0;
    end
  end

  always_comb begin
    status                        = '0;
    status[ST_FIELD]              = field;
    status[ST_BLANK]              = blank;
    status[ST_STD]                = std_q;
    status[ST_LACE_HI:ST_LACE_LO] = lace_q;
    status[ST_HALF]               = ~field;
  end

  // R6: one step per frame boundary
  a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_end) |-> frame_cnt == $past(frame_cnt) + 1'b1);

  a_r6_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_end) |-> $stable(frame_cnt));

  // R8: a set field requires interlace and an odd frame
  a_r8_field_lace: assert property (@(posedge clk) disable iff (!rst_n)
    field |-> (lace_q == LACE_ON) && frame_cnt[0]);

endmodule

// File: rtl/vt_timing_gen.sv
module vt_timing_gen
  import vt_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 33_868_800,
  parameter int unsigned RATE_A     = 60,
  parameter int unsigned RATE_B     = 50,
  parameter int unsigned LINES_A    = 263,
  parameter int unsigned LINES_B    = 314,
  parameter int unsigned VBL_LINE   = 240,
  parameter int unsigned FCNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_sel_i,
  input  logic [1:0]        lace_cfg_i,
  output logic              line_tick_o,
  output logic              blank_o,
  output logic              unblank_o,
  output logic              vblank_irq_o,
  output logic              field_o,
  output logic [8:0]        line_num_o,
  output logic [FCNT_W-1:0] frame_cnt_o,
  output logic [31:0]       status_o
);

  localparam int unsigned PER_A  = line_period(SYS_CLK_HZ, RATE_A, LINES_A);
  localparam int unsigned PER_B  = line_period(SYS_CLK_HZ, RATE_B, LINES_B);
  localparam int unsigned PER_W  = $clog2(max2(PER_A, PER_B) + 1);
  localparam int unsigned LINE_W = 9;

  vstd_e             std_q;
  logic              tick_end;
  logic              frame_end;
  logic [LINE_W-1:0] line_q;

  vt_line_divider #(
    .PER_W (PER_W),
    .PER_A (PER_A),
    .PER_B (PER_B)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .std_q     (std_q),
    .tick_end  (tick_end),
    .line_tick (line_tick_o)
  );

  vt_frame_seq #(
    .LINE_W   (LINE_W),
    .LINES_A  (LINES_A),
    .LINES_B  (LINES_B),
    .VBL_LINE (VBL_LINE)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_end   (tick_end),
    .std_sel_i  (std_sel_i),
    .std_q      (std_q),
    .line_q     (line_q),
    .blank      (blank_o),
    .unblank    (unblank_o),
    .vblank_irq (vblank_irq_o),
    .frame_end  (frame_end)
  );

  vt_field_status #(
    .FCNT_W (FCNT_W)
  ) u_fld (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_end  (frame_end),
    .lace_cfg_i (lace_cfg_i),
    .blank      (blank_o),
    .std_q      (std_q),
    .frame_cnt  (frame_cnt_o),
    .field      (field_o),
    .status     (status_o)
  );

  assign line_num_o = line_q;

  // R6: frame start and frame count move together, on a line tick
  a_r6_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    unblank_o |-> line_tick_o && !$stable(frame_cnt_o));

  // R3: line number never reaches the 50 Hz total
  a_r3_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
    line_num_o < 9'(LINES_B));

endmodule

// File: tb/test_vt_timing_gen.sv
module test_vt_timing_gen;

  localparam int SYS = 47340;   // gives a 3-cycle line in both standards
  localparam int P   = 3;
  localparam int VBL = 240;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        std_sel = 1'b1;
  logic [1:0]  lace = 2'b00;
  logic        line_tick, blank, unblank, virq, field;
  logic [8:0]  line_num;
  logic [15:0] frame_cnt;
  logic [31:0] status;

  always #2 clk = ~clk;   // 250 MHz

  vt_timing_gen #(.SYS_CLK_HZ(SYS)) i_vt_timing_gen (
    .clk(clk), .rst_n(rst_n), .std_sel_i(std_sel), .lace_cfg_i(lace),
    .line_tick_o(line_tick), .blank_o(blank), .unblank_o(unblank),
    .vblank_irq_o(virq), .field_o(field), .line_num_o(line_num),
    .frame_cnt_o(frame_cnt), .status_o(status)
  );

  typedef struct {
    int cyc; bit is_frame; int cnt; bit fld; bit std; logic [1:0] lc;
  } ev_t;

  ev_t q[$];
  int  cyc = 0;
  int  n_chk = 0, n_fail = 0;
  bit  mon_on = 0;
  int  last_tick = 0;
  int  m_line = 0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // monitor: line ticks and scoreboard events
  always @(negedge clk) begin
    if (mon_on) begin
      if (line_tick) begin
        chk(cyc - last_tick == P, "R2 tick spacing", cyc - last_tick, P);
        last_tick = cyc;
        if (unblank) m_line = 0; else m_line++;
        chk(line_num == 9'(m_line), "R3 line number", line_num, m_line);
        chk(blank == (m_line >= VBL), "R4 blank vs line", blank, m_line >= VBL);
      end
      if (q.size() != 0 && cyc > q[0].cyc) begin
        chk(0, q[0].is_frame ? "R6 frame start missing" : "R5 irq missing", cyc, q[0].cyc);
        void'(q.pop_front());
      end
      if (virq || unblank) begin
        if (q.size() == 0) begin
          chk(0, virq ? "R5 unexpected irq" : "R6 unexpected frame start", cyc, 0);
        end else begin
          ev_t e;
          e = q.pop_front();
          chk(cyc == e.cyc, e.is_frame ? "R3 frame end cycle" : "R5 irq cycle", cyc, e.cyc);
          chk(unblank == e.is_frame && virq == !e.is_frame, "R5 R6 event kind",
              {virq, unblank}, {!e.is_frame, e.is_frame});
          chk(line_tick, "R2 tick with event", line_tick, 1);
          if (e.is_frame) begin
            chk(line_num == 0 && !blank, "R6 wrap line/blank", {blank, line_num}, 0);
            chk(frame_cnt == 16'(e.cnt), "R6 frame count", frame_cnt, e.cnt);
            chk(field == e.fld, "R8 field", field, e.fld);
            chk(status[29] == e.std, "R7 standard in status", status[29], e.std);
            chk(status == ({e.fld, 1'b0, e.std, e.lc, 27'd0} | {18'd0, ~e.fld, 13'd0}),
                "R9 status word", status,
                {e.fld, 1'b0, e.std, e.lc, 27'd0} | {18'd0, ~e.fld, 13'd0});
          end else begin
            chk(line_num == 9'(VBL) && blank, "R5 irq line", line_num, VBL);
            chk(status[30], "R9 status blank", status[30], 1);
          end
        end
      end
    end
  end

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // driver: plans each frame and pushes its expected events
  task automatic run_all();
    int s = 0;
    bit cur_std = 0;
    bit nxt_std [5] = '{1, 1, 0, 0, 1};
    logic [1:0] nxt_lc [5] = '{2'b00, 2'b11, 2'b11, 2'b10, 2'b11};
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    chk({line_num, frame_cnt, field, blank, line_tick, unblank, virq} == 0,
        "R1 reset outputs", {line_num, frame_cnt}, 0);
    chk(status == 32'h0000_2000, "R1 reset status", status, 32'h2000);
    rst_n = 1'b1;
    mon_on = 1;
    @(negedge clk);
    chk(line_num == 0 && !line_tick && !blank, "R1 first cycle", line_num, 0);
    for (int k = 0; k < 5; k++) begin
      int tot = cur_std ? 314 : 263;
      ev_t a, b;
      bit fl = (nxt_lc[k] == 2'b11) ? bit'((k + 1) & 1) : 1'b0;
      a = '{s + VBL * P, 1'b0, 0, 1'b0, 1'b0, 2'b00};
      b = '{s + tot * P, 1'b1, k + 1, fl, nxt_std[k], nxt_lc[k]};
      q.push_back(a);
      q.push_back(b);
      // R7 R8: mid-frame glitches on the sampled inputs
      wait_cyc(s + 10 * P);
      std_sel = ~nxt_std[k];
      lace = ~nxt_lc[k];
      wait_cyc(s + 20 * P);
      chk(status[29] == cur_std, "R7 mid-frame standard held", status[29], cur_std);
      wait_cyc(s + 100 * P);
      std_sel = nxt_std[k];
      lace = nxt_lc[k];
      s = s + tot * P;
      cur_std = nxt_std[k];
    end
    wait_cyc(s + 5);
    chk(q.size() == 0, "R6 all events seen", q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", cyc, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule